// File: doc/BRIEF.md
# Double-Precision Compare Unit

This block evaluates one of four relations between two 64-bit IEEE-754 binary64 operands: unordered, equal, less-than and less-or-equal. An instruction word selects the relation and names the destination and source registers. The unit returns a 64-bit result word for the register file, the register fields, and exception flags for invalid operation, denormal input and illegal function code.

Operands are classified as zero, denormal, normal, infinity, quiet NaN or signaling NaN. A control input can make denormal operands count as zero in the comparison. Both the input side and the output side use a valid/ready handshake. Each accepted request produces one registered response on the next clock edge, and that response is held while the consumer stalls.

Top module: `fp_compare_unit`

## Requirements
- R1: The function code is taken from instruction bits 8:5. Code 4 selects unordered, 5 selects equal, 6 selects less-than (a < b) and 7 selects less-or-equal (a <= b).
- R2: A true relation returns the result word 0x4000000000000000 and a false relation returns zero, with the result write enable high.
- R3: When either operand is a NaN, less-than and less-or-equal raise the invalid flag and return false.
- R4: Equal and unordered raise the invalid flag only when at least one operand is a signaling NaN (exponent all ones, fraction non-zero, fraction bit 51 clear). A quiet NaN (fraction bit 51 set) alone does not raise it.
- R5: An operand with a zero exponent and a non-zero fraction raises the denormal flag, whatever the value of the denormal-as-zero input.
- R6: When the denormal-as-zero input is high, a denormal operand compares as zero. When it is low, the operand compares by its actual value.
- R7: Positive zero and negative zero compare equal.
- R8: The unordered relation is true exactly when at least one operand is a NaN.
- R9: Function codes 0 to 3 and 8 to 15 raise the illegal flag, hold the result write enable low with a zero result word, and raise neither the invalid nor the denormal flag.
- R10: The destination field (bits 4:0), the first source field (bits 25:21) and the second source field (bits 20:16) come out alongside the result.
- R11: A request accepted on a clock edge produces a valid response after that edge. While the output is valid and not taken, the input is not ready and the response stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A request is present |
| in_ready | output | 1 | The unit can accept a request |
| insn | input | 32 | Instruction word |
| op_a | input | 64 | First operand, binary64 |
| op_b | input | 64 | Second operand, binary64 |
| daz | input | 1 | Treat denormal operands as zero |
| out_valid | output | 1 | A response is present |
| out_ready | input | 1 | The consumer takes the response |
| res_we | output | 1 | The result word is to be written |
| res | output | 64 | Result word |
| rd | output | 5 | Destination register field |
| rs_a | output | 5 | First source register field |
| rs_b | output | 5 | Second source register field |
| flag_inv | output | 1 | Invalid-operation exception |
| flag_den | output | 1 | Denormal-operand exception |
| flag_ill | output | 1 | Illegal function code |

## Verification
Every response is due one clock edge after its request is accepted. The bench drives a request at a falling edge and samples the response at the next falling edge, half a period after the register loads. In the stall case, the bench keeps the response and in_ready under observation over extra falling edges while out_ready is low, and expects no change until out_ready is raised.

// File: rtl/fp_compare_unit.sv
module fp_compare_unit #(
  parameter int  DW        = 64,
  parameter int  EW        = 11,
  parameter int  RW        = 5,
  parameter int  IW        = 32,
  parameter logic [63:0] TRUE_WORD = 64'h4000_0000_0000_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [IW-1:0] insn,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  input  logic          daz,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          res_we,
  output logic [DW-1:0] res,
  output logic [RW-1:0] rd,
  output logic [RW-1:0] rs_a,
  output logic [RW-1:0] rs_b,
  output logic          flag_inv,
  output logic          flag_den,
  output logic          flag_ill
);
  localparam int FW = DW - EW - 1;

  logic [EW-1:0] ea, eb;
  logic [FW-1:0] fa, fb;
  logic a_nan, b_nan, a_snan, b_snan, a_den, b_den, a_zero, b_zero;
  logic [DW-1:0] ka, kb;
  logic [3:0] func;
  logic legal, unord, eq, lt, truth, inv, fire;

  assign ea = op_a[DW-2 -: EW];
  assign eb = op_b[DW-2 -: EW];
  assign fa = op_a[FW-1:0];
  assign fb = op_b[FW-1:0];

  assign a_nan  = (&ea) && (fa != '0);
  assign b_nan  = (&eb) && (fb != '0);
  assign a_snan = a_nan && !fa[FW-1];
  assign b_snan = b_nan && !fb[FW-1];
  assign a_den  = (ea == '0) && (fa != '0);
  assign b_den  = (eb == '0) && (fb != '0);
  assign a_zero = (ea == '0) && ((fa == '0) || daz);
  assign b_zero = (eb == '0) && ((fb == '0) || daz);

  assign ka = a_zero ? {1'b1, {(DW-1){1'b0}}} :
              op_a[DW-1] ? ~op_a : {1'b1, op_a[DW-2:0]};
  assign kb = b_zero ? {1'b1, {(DW-1){1'b0}}} :
              op_b[DW-1] ? ~op_b : {1'b1, op_b[DW-2:0]};

  assign func  = insn[8:5];
  assign legal = (func[3:2] == 2'b01);
  assign unord = a_nan || b_nan;
  assign eq    = !unord && (ka == kb);
  assign lt    = !unord && (ka < kb);

  always_comb begin
    case (func[1:0])
      2'd0:    truth = unord;
      2'd1:    truth = eq;
      2'd2:    truth = lt;
      default: truth = lt || eq;
    endcase
  end

  assign inv      = unord && (func[1] || a_snan || b_snan);
  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res_we    <= 1'b0;
      res       <= '0;
      rd        <= '0;
      rs_a      <= '0;
      rs_b      <= '0;
      flag_inv  <= 1'b0;
      flag_den  <= 1'b0;
      flag_ill  <= 1'b0;
    end else if (fire) begin
      out_valid <= 1'b1;
      res_we    <= legal;
      res       <= (legal && truth) ? TRUE_WORD : '0;
      rd        <= insn[4:0];
      rs_a      <= insn[25:21];
      rs_b      <= insn[20:16];
      flag_inv  <= legal && inv;
      flag_den  <= legal && (a_den || b_den);
      flag_ill  <= !legal;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_RES_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (res == '0 || res == TRUE_WORD)) else $error("res pattern"); // R2
  AST_ILL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flag_ill) |-> (!res_we && res == '0 && !flag_inv && !flag_den)) else $error("illegal write"); // R9
  AST_ILL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (flag_ill != res_we)) else $error("ill/we"); // R9
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid) else $error("latency"); // R11
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(res) && $stable(rd) && $stable(flag_inv))) else $error("stall"); // R11
  AST_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (rd == $past(insn[4:0]) && rs_a == $past(insn[25:21]) && rs_b == $past(insn[20:16]))) else $error("fields"); // R10
  AST_ORDERED_NAN_INV: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && insn[8:6] == 3'b011 && (a_nan || b_nan)) |=> (flag_inv && res == '0)) else $error("nan inv"); // R3
endmodule

// File: tb/fp_compare_unit_tb.sv
`timescale 1ns/1ps
module fp_compare_unit_tb;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready, daz = 0, out_valid, out_ready = 1;
  logic [31:0] insn = '0;
  logic [63:0] op_a = '0, op_b = '0, res;
  logic res_we, flag_inv, flag_den, flag_ill;
  logic [4:0] rd, rs_a, rs_b;
  int n_chk = 0, n_bad = 0;
  localparam logic [63:0] TW = 64'h4000_0000_0000_0000;

  always #4 clk = ~clk;

  fp_compare_unit u_dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .insn(insn), .op_a(op_a), .op_b(op_b), .daz(daz), .out_valid(out_valid), .out_ready(out_ready),
    .res_we(res_we), .res(res), .rd(rd), .rs_a(rs_a), .rs_b(rs_b),
    .flag_inv(flag_inv), .flag_den(flag_den), .flag_ill(flag_ill));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit is_nan(input logic [63:0] x);
    return x[62:52] == 11'h7ff && x[51:0] != 0;
  endfunction
  function automatic bit is_snan(input logic [63:0] x);
    return is_nan(x) && !x[51];
  endfunction
  function automatic bit is_den(input logic [63:0] x);
    return x[62:52] == 0 && x[51:0] != 0;
  endfunction
  // -1 less, 0 equal, 1 greater, 2 unordered
  function automatic int rel(input logic [63:0] a, input logic [63:0] b, input bit dz);
    bit za, zb;
    if (is_nan(a) || is_nan(b)) return 2;
    za = a[62:0] == 0 || (dz && is_den(a));
    zb = b[62:0] == 0 || (dz && is_den(b));
    if (za && zb) return 0;
    if (za) return b[63] ? 1 : -1;
    if (zb) return a[63] ? -1 : 1;
    if (a[63] != b[63]) return a[63] ? -1 : 1;
    if (a[62:0] == b[62:0]) return 0;
    if (a[63]) return (a[62:0] > b[62:0]) ? -1 : 1;
    return (a[62:0] < b[62:0]) ? -1 : 1;
  endfunction

  function automatic logic [31:0] mk(input logic [3:0] f, input logic [4:0] ra, input logic [4:0] rb, input logic [4:0] rc);
    logic [6:0] mid = 7'($urandom);
    return {6'h16, ra, rb, mid, f, rc};
  endfunction

  function automatic logic [63:0] pick();
    logic [63:0] r = {$urandom, $urandom};
    case ($urandom % 8)
      0: return {r[63], 63'h0};
      1: return {r[63], 11'h0, r[51:1], 1'b1};
      2: return {r[63], 11'h3ff + 11'(r[5:0]) - 11'd32, r[51:0]};
      3: return {r[63], 11'h7ff, 52'h0};
      4: return {r[63], 11'h7ff, 1'b1, r[50:0]};
      5: return {r[63], 11'h7ff, 1'b0, r[50:1], 1'b1};
      6: return {r[63], 11'h3ff, 52'h0};
      default: return r;
    endcase
  endfunction

  task automatic run(input logic [31:0] w, input logic [63:0] a, input logic [63:0] b, input bit dz, input string tag);
    int r; bit lg, t, inv; logic [3:0] f = w[8:5];
    @(negedge clk);
    insn = w; op_a = a; op_b = b; daz = dz; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    r = rel(a, b, dz);
    lg = f >= 4 && f <= 7;
    case (f)
      4: t = r == 2;
      5: t = r == 0;
      6: t = r == -1;
      7: t = r == -1 || r == 0;
      default: t = 0;
    endcase
    inv = lg && r == 2 && (f >= 6 || is_snan(a) || is_snan(b));
    chk({tag, " R11 out_valid"}, 64'(out_valid), 64'd1);
    chk({tag, " R1 R2 result"}, res, (lg && t) ? TW : 64'h0);
    chk({tag, " R9 res_we"}, 64'(res_we), 64'(lg));
    chk({tag, " R9 flag_ill"}, 64'(flag_ill), 64'(!lg));
    chk({tag, " R3 R4 flag_inv"}, 64'(flag_inv), 64'(inv));
    chk({tag, " R5 flag_den"}, 64'(flag_den), 64'(lg && (is_den(a) || is_den(b))));
    chk({tag, " R10 fields"}, {49'h0, rd, rs_a, rs_b}, {49'h0, w[4:0], w[25:21], w[20:16]});
  endtask

  localparam logic [63:0] QN = 64'h7ff8_0000_0000_0001, SN = 64'h7ff0_0000_0000_0001;
  localparam logic [63:0] ONE = 64'h3ff0_0000_0000_0000, DEN = 64'h0000_0000_0000_0005;

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk("R11 reset out_valid", 64'(out_valid), 64'd0);
    chk("R11 reset in_ready", 64'(in_ready), 64'd1);
    rst_n = 1;
    run(mk(4'd5, 1, 2, 3), 64'h0, 64'h8000_0000_0000_0000, 0, "R7 +0 eq -0");
    run(mk(4'd7, 1, 2, 3), 64'h8000_0000_0000_0000, 64'h0, 0, "R7 -0 le +0");
    run(mk(4'd6, 4, 5, 6), QN, ONE, 0, "R3 lt qnan");
    run(mk(4'd7, 4, 5, 6), ONE, QN, 0, "R3 le qnan");
    run(mk(4'd5, 4, 5, 6), QN, ONE, 0, "R4 eq qnan no inv");
    run(mk(4'd4, 4, 5, 6), ONE, QN, 0, "R4 R8 un qnan");
    run(mk(4'd5, 4, 5, 6), SN, ONE, 0, "R4 eq snan");
    run(mk(4'd4, 4, 5, 6), ONE, SN, 0, "R4 un snan");
    run(mk(4'd4, 7, 8, 9), ONE, ONE, 0, "R8 un ordered");
    run(mk(4'd5, 7, 8, 9), DEN, 64'h0, 1, "R6 daz eq");
    run(mk(4'd5, 7, 8, 9), DEN, 64'h0, 0, "R6 no daz ne");
    run(mk(4'd6, 7, 8, 9), 64'h0, DEN, 0, "R5 R6 lt den");
    run(mk(4'd3, 10, 11, 12), ONE, ONE, 0, "R9 func 3");
    run(mk(4'd8, 10, 11, 12), SN, DEN, 0, "R9 func 8");
    run(mk(4'd6, 31, 0, 17), 64'hc000_0000_0000_0000, ONE, 0, "R1 lt neg");
    // stall: response held, input blocked
    @(negedge clk);
    out_ready = 0; insn = mk(4'd6, 1, 1, 1); op_a = 64'hbff0_0000_0000_0000; op_b = ONE; in_valid = 1;
    @(negedge clk);
    insn = mk(4'd4, 2, 2, 2); op_a = ONE; op_b = ONE;
    chk("R11 stall in_ready", 64'(in_ready), 64'd0);
    @(negedge clk);
    chk("R11 stall held valid", 64'(out_valid), 64'd1);
    chk("R11 stall held res", res, TW);
    in_valid = 0; out_ready = 1;
    @(negedge clk);
    chk("R11 drained", 64'(out_valid), 64'd0);
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] a = pick();
      logic [63:0] b = ($urandom % 6 == 0) ? a : pick();
      logic [3:0] f = ($urandom % 8 == 0) ? 4'($urandom) : 4'(4 + $urandom % 4);
      run(mk(f, 5'($urandom), 5'($urandom), 5'($urandom)), a, b, 1'($urandom), "rand");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule